// File: doc/BRIEF.md
# PCIe Electrical Idle Inference Unit

This unit sits in one receiver channel and decides that the far end has gone to electrical idle because expected traffic has stopped arriving, not because an analog squelch circuit says so. A separate decoder supplies one-cycle strobes for the ordered sets and packets it recognises: TS1, TS2, skip and flow-control update. A 3-bit rule select, driven by the link training logic to match the current link state, picks which strobes count as traffic and which timebase measures the silence. A link of width x1, x4 or x8 uses one copy of the unit per lane.

Two rules are defined. In the normal running state the unit watches for skip ordered sets and flow-control updates. It counts ticks of an external 1 µs pulse and infers idle after 128 µs with neither. In the receiver-configuration and post-negotiation speed-change substates it watches for TS1 and TS2 ordered sets. It counts symbol-clock cycles, and infers idle after 128 cycles with neither (1280 UI at 10 UI per symbol). The output stays high until a qualifying strobe arrives. Any change of the select starts the new rule with a fresh window. A select value that is not one of the two defined codes disables inference.

Top module: `eidle_infer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `elec_idle` is low.
- R2: With `rule_sel` = 3'b101, `elec_idle` goes high on the clock edge that ends the 128th consecutive cycle after the last restart in which neither `sym_ts1` nor `sym_ts2` was sampled high. It is still low after 127 such cycles. `us_tick` has no effect in this rule.
- R3: With `rule_sel` = 3'b101, a cycle with `sym_ts1` or `sym_ts2` high makes `elec_idle` low from the next edge and restarts the 128-cycle window.
- R4: With `rule_sel` = 3'b100, `elec_idle` goes high on the edge that samples the 128th `us_tick` pulse counted since the last restart, provided neither `sym_fc_update` nor `sym_skp` was high in between. It is still low after 127 such pulses. Cycles without `us_tick` do not advance the window.
- R5: With `rule_sel` = 3'b100, a cycle with `sym_fc_update` or `sym_skp` high makes `elec_idle` low from the next edge and restarts the window.
- R6: In rule 3'b100 the strobes `sym_ts1` and `sym_ts2` neither clear nor restart the window. In rule 3'b101 the strobes `sym_skp` and `sym_fc_update` neither clear nor restart it.
- R7: A cycle in which `rule_sel` differs from its value in the previous cycle (taken as 3'b000 right after reset) clears `elec_idle` from the next edge. It also restarts the window of the newly selected rule.
- R8: For any `rule_sel` value other than 3'b100 and 3'b101, `elec_idle` is low from the next edge, however long the silence lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rule_sel | input | 3 | Inference rule select matching the link substate |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| sym_ts1 | input | 1 | TS1 ordered set received this cycle |
| sym_ts2 | input | 1 | TS2 ordered set received this cycle |
| sym_skp | input | 1 | Skip ordered set received this cycle |
| sym_fc_update | input | 1 | Flow-control update received this cycle |
| elec_idle | output | 1 | Inferred electrical idle, registered |

## Verification
The bench probes the exact window edge in both rules: low after 127 silent cycles or ticks, high after 128. A design with an off-by-one counter would assert idle a cycle or tick early or late. It also sends strobes from the rule that is not selected while idle is high. A design that mixed up the watched symbol sets would drop idle there, or would fail to drop it on the proper strobe. Select changes and undefined select codes come while idle is high or a window is partly counted. A design that carried its count across rules would assert idle too soon after the change, and one that ignored undefined codes would assert it during a long silence.

// File: rtl/eidle_pkg.sv
package eidle_pkg;
  localparam logic [2:0] SEL_L0  = 3'b100;
  localparam logic [2:0] SEL_RCV = 3'b101;

  typedef enum logic [1:0] {
    RULE_OFF = 2'd0,
    RULE_L0  = 2'd1,
    RULE_RCV = 2'd2
  } rule_e;
endpackage

// File: rtl/eidle_rule_dec.sv
module eidle_rule_dec
  import eidle_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rule_sel,
  output rule_e      rule,
  output logic       sel_chg
);
  logic [2:0] sel_q;
  logic [2:0] sel_d;

  always_comb begin
    unique case (rule_sel)
      SEL_L0:  rule = RULE_L0;
      SEL_RCV: rule = RULE_RCV;
      default: rule = RULE_OFF;
    endcase
  end

  always_comb begin
    sel_d   = rule_sel;
    sel_chg = (rule_sel != sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 3'b000;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/eidle_window_timer.sv
module eidle_window_timer #(
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output logic idle
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             idle_q, idle_d;

  always_comb begin
    cnt_d  = cnt_q;
    idle_d = idle_q;
    if (clear) begin
      cnt_d  = '0;
      idle_d = 1'b0;
    end else if (advance) begin
      if (cnt_q == LAST) idle_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      idle_q <= idle_d;
    end
  end

  assign idle = idle_q;

  // R3 and R5: a qualifying strobe or restart drops idle on the next edge
  p_clear_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !idle_q);

  // R2 and R4: once inferred, idle persists until a restart
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && !clear) |=> idle_q);

  // R4: idle only ever rises on an edge where the timebase advanced
  p_rise_on_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> $past(advance));
endmodule

// File: rtl/eidle_infer.sv
module eidle_infer
  import eidle_pkg::*;
#(
  parameter int SYM_WINDOW = 128,
  parameter int US_WINDOW  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rule_sel,
  input  logic       us_tick,
  input  logic       sym_ts1,
  input  logic       sym_ts2,
  input  logic       sym_skp,
  input  logic       sym_fc_update,
  output logic       elec_idle
);
  rule_e rule;
  logic  sel_chg;
  logic  clr_l0, clr_rcv, adv_l0, adv_rcv;
  logic  idle_l0, idle_rcv;

  eidle_rule_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .rule_sel (rule_sel),
    .rule     (rule),
    .sel_chg  (sel_chg)
  );

  always_comb begin
    clr_l0  = (rule != RULE_L0)  || sel_chg || sym_fc_update || sym_skp;
    clr_rcv = (rule != RULE_RCV) || sel_chg || sym_ts1 || sym_ts2;
    adv_l0  = us_tick;
    adv_rcv = 1'b1;
  end

  eidle_window_timer #(.LIMIT(US_WINDOW)) u_win_l0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clr_l0),
    .advance (adv_l0),
    .idle    (idle_l0)
  );

  eidle_window_timer #(.LIMIT(SYM_WINDOW)) u_win_rcv (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clr_rcv),
    .advance (adv_rcv),
    .idle    (idle_rcv)
  );

  assign elec_idle = idle_l0 | idle_rcv;

  // R8: undefined codes hold the output low
  p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rule == RULE_OFF) |=> !elec_idle);

  // R7: a select change drops idle on the next edge
  p_sel_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> !elec_idle);

  // R6: at most one rule's timer reports idle at a time
  p_one_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idle_l0, idle_rcv}));
endmodule

// File: tb/eidle_infer_tb.sv
module eidle_infer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rule_sel = 3'b000;
  logic       us_tick = 1'b0, sym_ts1 = 1'b0, sym_ts2 = 1'b0;
  logic       sym_skp = 1'b0, sym_fc_update = 1'b0;
  logic       elec_idle;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  int       m_silent = 0;
  bit       m_idle = 1'b0;
  bit [2:0] m_prev = 3'b000;

  always #5 clk = ~clk;

  eidle_infer u_dut (
    .clk(clk), .rst_n(rst_n), .rule_sel(rule_sel), .us_tick(us_tick),
    .sym_ts1(sym_ts1), .sym_ts2(sym_ts2), .sym_skp(sym_skp),
    .sym_fc_update(sym_fc_update), .elec_idle(elec_idle)
  );

  task automatic chk(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: elec_idle=%b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  // one clock: apply inputs at negedge, advance model, compare after the edge
  task automatic step(input bit [2:0] sel, input bit tk, input bit t1,
                      input bit t2, input bit sk, input bit fc);
    bit chg, on, qual, adv;
    @(negedge clk);
    rule_sel = sel; us_tick = tk; sym_ts1 = t1; sym_ts2 = t2;
    sym_skp = sk; sym_fc_update = fc;
    chg    = (sel != m_prev);
    m_prev = sel;
    on     = (sel == 3'b100) || (sel == 3'b101);
    qual   = (sel == 3'b100) ? (fc || sk) : (t1 || t2);
    adv    = (sel == 3'b100) ? tk : 1'b1;
    if (!on || chg || qual) begin
      m_silent = 0;
      m_idle   = 1'b0;
    end else if (adv) begin
      m_silent++;
      if (m_silent >= 128) m_idle = 1'b1;
    end
    @(posedge clk);
    #1;
    chk(tag, elec_idle, m_idle);
  endtask

  task automatic quiet(input bit [2:0] sel, input int n);
    for (int i = 0; i < n; i++) step(sel, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // n microsecond ticks, each followed by three idle cycles
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      quiet(3'b100, 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset", elec_idle, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 after reset", elec_idle, 1'b0);

    // R2: symbol window edge
    tag = "R2";
    quiet(3'b101, 128);
    chk("R2 after 127 silent", elec_idle, 1'b0);
    quiet(3'b101, 1);
    chk("R2 after 128 silent", elec_idle, 1'b1);
    for (int i = 0; i < 5; i++) step(3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 tick ignored", elec_idle, 1'b1);

    // R6: skip/FC ignored in RCV
    tag = "R6";
    step(3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 skp/fc in rcv", elec_idle, 1'b1);

    // R3: TS clears and restarts
    tag = "R3";
    step(3'b101, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 ts2 clears", elec_idle, 1'b0);
    quiet(3'b101, 60);
    step(3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    quiet(3'b101, 127);
    chk("R3 restart 127", elec_idle, 1'b0);
    quiet(3'b101, 1);
    chk("R3 restart 128", elec_idle, 1'b1);

    // R7: change to L0 while idle
    tag = "R7";
    step(3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 change clears", elec_idle, 1'b0);

    // R4: microsecond window edge
    tag = "R4";
    ticks(127);
    chk("R4 after 127 ticks", elec_idle, 1'b0);
    quiet(3'b100, 20);
    chk("R4 no tick no advance", elec_idle, 1'b0);
    ticks(1);
    chk("R4 after 128 ticks", elec_idle, 1'b1);

    // R6: TS ignored in L0
    tag = "R6";
    step(3'b100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 ts in l0", elec_idle, 1'b1);

    // R5: skip and FC clear
    tag = "R5";
    step(3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5 skp clears", elec_idle, 1'b0);
    ticks(128);
    chk("R5 re-idle", elec_idle, 1'b1);
    step(3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 fc clears", elec_idle, 1'b0);
    ticks(100);

    // R7: partial count not carried across a rule swap
    tag = "R7";
    quiet(3'b101, 100);
    step(3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    quiet(3'b101, 128);
    chk("R7 fresh window 127", elec_idle, 1'b0);
    quiet(3'b101, 1);
    chk("R7 fresh window 128", elec_idle, 1'b1);

    // R8: undefined codes
    tag = "R8";
    quiet(3'b011, 1);
    chk("R8 011 clears", elec_idle, 1'b0);
    quiet(3'b011, 300);
    chk("R8 011 long silence", elec_idle, 1'b0);
    for (int i = 0; i < 600; i++) step(3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 111 long silence", elec_idle, 1'b0);
    quiet(3'b000, 200);
    chk("R8 000 long silence", elec_idle, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule